// File: doc/BRIEF.md
# Full-Bridge Adaptive Dead-Time Sequencer

This block sits between the commutation logic of a full-bridge driver and the four gate drivers. It receives a one-bit request that names which diagonal pair of switches should conduct. Pair A is the high-left and low-right switch, and pair B is the high-right and low-left switch. The block produces four registered gate enables. Whenever the request changes, it switches off the conducting pair and then waits through a non-overlap gap before it switches on the other pair.

The gap adapts to the load. It lasts at least a fixed number of clock cycles. After that minimum it ends as soon as the node of the half-bridge that is swinging reports that its slope is over. A slope-sense flag is given for each side, and the flag that matters is the one for the side whose high switch has just turned off. If the slope never ends, a maximum gap length forces completion. Three further controls override the sequencing:

- A lockout flag for each side holds that side's high switch off while its floating supply is too low.
- A disable input switches every gate off at once, and this aborts any gap that is in progress.
- Slope sensing and supply comparison are modelled as synchronous digital inputs.

Top module: `dt_seq_top`

## Requirements
- R1: While reset is asserted, and after it is released, all four gates are low. With `bridge_off` low, the first pair turns on after exactly `MIN_CYC` cycles of all-off. Slope flags are ignored for this first gap.
- R2: `pair_req`=0 selects pair A (`gate_hi_l`=1 and `gate_lo_r`=1). `pair_req`=1 selects pair B (`gate_hi_r`=1 and `gate_lo_l`=1). A held request keeps its pair on, and the other two gates stay low.
- R3: When `pair_req` differs from the conducting pair at a clock edge, all four gates are low after that edge. No gate of the new pair rises during the gap.
- R4: A gap lasts at least `MIN_CYC` cycles, even when the relevant slope flag is already low or drops early.
- R5: Leaving pair A watches `slope_l`, and leaving pair B watches `slope_r`. The flag of the other side has no effect. The gap length is max(`MIN_CYC`, number of edges at which the watched flag was sampled high since the gap started).
- R6: If the watched slope flag never drops, the gap ends after exactly `MAX_CYC` cycles.
- R7: A request change during a gap does not alter the gap in progress. The gap completes with the pair that started it. If the request then differs, a new gap begins at the next edge, so that pair is on for one cycle.
- R8: `bridge_off` sampled high at an edge makes all four gates low after that edge, including during a gap. After release, the requested pair turns on after exactly `MIN_CYC` cycles, and both slope flags are ignored.
- R9: `hs_lock_l` (`hs_lock_r`) sampled high at an edge holds `gate_hi_l` (`gate_hi_r`) low after that edge. It does not affect the low-side gate of the same pair.
- R10: The high and low gate of the same side are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_off | input | 1 | Forces all gates off while high |
| pair_req | input | 1 | Requested pair: 0 = A, 1 = B |
| slope_l | input | 1 | Left node slope in progress |
| slope_r | input | 1 | Right node slope in progress |
| hs_lock_l | input | 1 | Left high-side supply below lockout |
| hs_lock_r | input | 1 | Right high-side supply below lockout |
| gate_hi_l | output | 1 | High-left gate enable |
| gate_hi_r | output | 1 | High-right gate enable |
| gate_lo_l | output | 1 | Low-left gate enable |
| gate_lo_r | output | 1 | Low-right gate enable |

## Verification
Two pairs of events are made to land in the same cycle:

- **A request reversal and gap completion.** The request flips back part-way through a gap. The gap completes and hands over in the same edge as the ON state notices the mismatch, so the bench expects the new pair for exactly one cycle followed by a fresh full-minimum gap.
- **Disable and a running gap.** `bridge_off` is raised while a gap is in progress, with slope flags held high. The bench expects all-off at the very next edge, and a release gap of exactly the minimum.

A behavioural model in the bench is compared with every output on every clock. Targeted gap-length measurements are checked against max(`MIN_CYC`, slope duration) and against `MAX_CYC`.

// File: rtl/dt_seq_pkg.sv
package dt_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF = 2'd0,
    SEQ_GAP = 2'd1,
    SEQ_ON  = 2'd2
  } seq_state_e;

  // Pair A: high-left + low-right; pair B: high-right + low-left
  typedef enum logic {
    PAIR_A = 1'b0,
    PAIR_B = 1'b1
  } pair_e;

endpackage

// File: rtl/dt_gap_timer.sv
module dt_gap_timer #(
  parameter int MIN_CYC = 112,
  parameter int MAX_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gap_clr,
  input  logic gap_run,
  input  logic slope_busy,
  output logic gap_done
);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(MIN_CYC - 1);
  localparam logic [CNT_W-1:0] MAX_LAST = CNT_W'(MAX_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             min_ok, max_ok;

  always_comb begin
    min_ok   = (cnt_q >= MIN_LAST);
    max_ok   = (cnt_q >= MAX_LAST);
    gap_done = gap_run && ((min_ok && !slope_busy) || max_ok);
    cnt_en   = gap_clr || (gap_run && !max_ok);
    cnt_d    = gap_clr ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dt_seq_fsm.sv
module dt_seq_fsm
  import dt_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bridge_off,
  input  logic       pair_req,
  input  logic       slope_l,
  input  logic       slope_r,
  input  logic       gap_done,
  output seq_state_e state_d,
  output pair_e      pair_d,
  output logic       gap_clr,
  output logic       gap_run,
  output logic       slope_busy
);
  seq_state_e state_q;
  pair_e      pair_q;
  logic       fresh_q, fresh_d;
  logic       upd_en;
  pair_e      req_pair;

  always_comb begin
    req_pair = pair_e'(pair_req);
    state_d  = state_q;
    pair_d   = pair_q;
    fresh_d  = fresh_q;
    if (bridge_off) begin
      state_d = SEQ_OFF;
    end else begin
      unique case (state_q)
        SEQ_OFF: begin
          state_d = SEQ_GAP;
          pair_d  = req_pair;
          fresh_d = 1'b1;
        end
        SEQ_GAP: begin
          if (gap_done) state_d = SEQ_ON;
        end
        SEQ_ON: begin
          if (req_pair != pair_q) begin
            state_d = SEQ_GAP;
            pair_d  = req_pair;
            fresh_d = 1'b0;
          end
        end
        default: state_d = SEQ_OFF;
      endcase
    end
    gap_run = (state_q == SEQ_GAP);
    gap_clr = (state_d == SEQ_GAP) && (state_q != SEQ_GAP);
    // heading to B means pair A left: its high side was on the left
    if (fresh_q) slope_busy = 1'b0;
    else if (pair_q == PAIR_B) slope_busy = slope_l;
    else slope_busy = slope_r;
    upd_en = (state_d != state_q) || (pair_d != pair_q) || (fresh_d != fresh_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_OFF;
      pair_q  <= PAIR_A;
      fresh_q <= 1'b1;
    end else if (upd_en) begin
      state_q <= state_d;
      pair_q  <= pair_d;
      fresh_q <= fresh_d;
    end
  end

endmodule

// File: rtl/dt_gate_stage.sv
module dt_gate_stage
  import dt_seq_pkg::*;
#(
  parameter int LEGS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            drive_on,
  input  pair_e           pair_d,
  input  logic [LEGS-1:0] hs_lock,
  output logic [LEGS-1:0] hi_q,
  output logic [LEGS-1:0] lo_q
);
  logic [LEGS-1:0] hi_d, lo_d;

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    localparam pair_e HI_PAIR = (g == 0) ? PAIR_A : PAIR_B;
    localparam pair_e LO_PAIR = (g == 0) ? PAIR_B : PAIR_A;

    always_comb begin
      hi_d[g] = drive_on && (pair_d == HI_PAIR) && !hs_lock[g];
      lo_d[g] = drive_on && (pair_d == LO_PAIR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= 1'b0;
        lo_q[g] <= 1'b0;
      end else begin
        hi_q[g] <= hi_d[g];
        lo_q[g] <= lo_d[g];
      end
    end
  end

endmodule

// File: rtl/dt_seq_top.sv
module dt_seq_top
  import dt_seq_pkg::*;
#(
  parameter int MIN_CYC = 112,
  parameter int MAX_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bridge_off,
  input  logic pair_req,
  input  logic slope_l,
  input  logic slope_r,
  input  logic hs_lock_l,
  input  logic hs_lock_r,
  output logic gate_hi_l,
  output logic gate_hi_r,
  output logic gate_lo_l,
  output logic gate_lo_r
);
  localparam int LEGS = 2;

  seq_state_e      state_d;
  pair_e           pair_d;
  logic            gap_clr, gap_run, gap_done, slope_busy;
  logic [LEGS-1:0] hi_q, lo_q;

  dt_seq_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bridge_off (bridge_off),
    .pair_req   (pair_req),
    .slope_l    (slope_l),
    .slope_r    (slope_r),
    .gap_done   (gap_done),
    .state_d    (state_d),
    .pair_d     (pair_d),
    .gap_clr    (gap_clr),
    .gap_run    (gap_run),
    .slope_busy (slope_busy)
  );

  dt_gap_timer #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gap_clr    (gap_clr),
    .gap_run    (gap_run),
    .slope_busy (slope_busy),
    .gap_done   (gap_done)
  );

  dt_gate_stage #(.LEGS(LEGS)) gates_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive_on (state_d == SEQ_ON),
    .pair_d   (pair_d),
    .hs_lock  ({hs_lock_r, hs_lock_l}),
    .hi_q     (hi_q),
    .lo_q     (lo_q)
  );

  assign gate_hi_l = hi_q[0];
  assign gate_hi_r = hi_q[1];
  assign gate_lo_l = lo_q[0];
  assign gate_lo_r = lo_q[1];

endmodule

// File: rtl/dt_seq_chk.sv
module dt_seq_chk #(
  parameter int MIN_CYC = 112
) (
  input logic clk,
  input logic rst_n,
  input logic bridge_off,
  input logic hs_lock_l,
  input logic hs_lock_r,
  input logic gate_hi_l,
  input logic gate_hi_r,
  input logic gate_lo_l,
  input logic gate_lo_r
);
  logic lo_on, lo_on_q;
  int   off_run;

  assign lo_on = gate_lo_l || gate_lo_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run <= 0;
      lo_on_q <= 1'b0;
    end else begin
      lo_on_q <= lo_on;
      if (lo_on) off_run <= 0;
      else if (off_run < MIN_CYC) off_run <= off_run + 1;
    end
  end

  a_r10_left_leg: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_l && gate_lo_l));
  a_r10_right_leg: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_r && gate_lo_r));
  a_r3_a_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi_l || gate_lo_r) |=> !(gate_hi_r || gate_lo_l));
  a_r3_b_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi_r || gate_lo_l) |=> !(gate_hi_l || gate_lo_r));
  a_r4_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_on && !lo_on_q) |-> (off_run >= MIN_CYC));
  a_r8_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_off |=> !(gate_hi_l || gate_hi_r || gate_lo_l || gate_lo_r));
  a_r9_lock_left: assert property (@(posedge clk) disable iff (!rst_n)
    hs_lock_l |=> !gate_hi_l);
  a_r9_lock_right: assert property (@(posedge clk) disable iff (!rst_n)
    hs_lock_r |=> !gate_hi_r);

endmodule

bind dt_seq_top dt_seq_chk #(.MIN_CYC(MIN_CYC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bridge_off (bridge_off),
  .hs_lock_l  (hs_lock_l),
  .hs_lock_r  (hs_lock_r),
  .gate_hi_l  (gate_hi_l),
  .gate_hi_r  (gate_hi_r),
  .gate_lo_l  (gate_lo_l),
  .gate_lo_r  (gate_lo_r)
);

// File: tb/dt_seq_top_tb_top.sv
module dt_seq_top_tb_top;
  localparam int MIN_CYC = 112;
  localparam int MAX_CYC = 400;

  logic clk = 1'b0;
  logic rst_n, bridge_off, pair_req, slope_l, slope_r, hs_lock_l, hs_lock_r;
  logic gate_hi_l, gate_hi_r, gate_lo_l, gate_lo_r;

  always #4 clk = ~clk;

  dt_seq_top #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bridge_off(bridge_off), .pair_req(pair_req),
    .slope_l(slope_l), .slope_r(slope_r), .hs_lock_l(hs_lock_l), .hs_lock_r(hs_lock_r),
    .gate_hi_l(gate_hi_l), .gate_hi_r(gate_hi_r), .gate_lo_l(gate_lo_l), .gate_lo_r(gate_lo_r)
  );

  int    total = 0;
  int    bad = 0;
  bit    cmp_en = 1'b0;
  bit    ended = 1'b0;
  string phase = "R1";

  // behavioural reference: mode 0 = all off, 1 = gap, 2 = pair on
  int       m_mode, m_tgt, m_act, m_n;
  bit       m_fresh;
  bit [3:0] m_g; // {hi_l, hi_r, lo_l, lo_r}

  always @(posedge clk or negedge rst_n) begin
    bit watch;
    if (!rst_n) begin
      m_mode = 0; m_n = 0; m_fresh = 1; m_g = 4'b0000; m_tgt = 0; m_act = 0;
    end else begin
      if (bridge_off) m_mode = 0;
      else if (m_mode == 0) begin
        m_mode = 1; m_tgt = int'(pair_req); m_fresh = 1; m_n = 0;
      end else if (m_mode == 1) begin
        watch = m_fresh ? 1'b0 : ((m_tgt == 1) ? slope_l : slope_r);
        if ((m_n >= MIN_CYC - 1 && !watch) || m_n >= MAX_CYC - 1) begin
          m_mode = 2; m_act = m_tgt;
        end else m_n++;
      end else if (int'(pair_req) != m_act) begin
        m_mode = 1; m_tgt = int'(pair_req); m_fresh = 0; m_n = 0;
      end
      m_g = 4'b0000;
      if (m_mode == 2) begin
        if (m_act == 0) m_g = {!hs_lock_l, 1'b0, 1'b0, 1'b1};
        else            m_g = {1'b0, !hs_lock_r, 1'b1, 1'b0};
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gates();
    return int'({gate_hi_l, gate_hi_r, gate_lo_l, gate_lo_r});
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(phase, gates(), int'(m_g));
      chk("R10", int'({gate_hi_l & gate_lo_l, gate_hi_r & gate_lo_r}), 0);
    end
  end

  task automatic gap_len(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!gate_lo_l && !gate_lo_r) n++;
      else break;
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; bridge_off = 1'b0; pair_req = 1'b0;
    slope_l = 1'b0; slope_r = 1'b0; hs_lock_l = 1'b0; hs_lock_r = 1'b0;
    @(negedge clk);
    cmp_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", gates(), 0);

    // R1: first pair after reset, slopes ignored
    slope_l = 1'b1; slope_r = 1'b1;
    rst_n = 1'b1;
    gap_len(n);
    chk("R1", n, MIN_CYC);
    phase = "R2";
    slope_l = 1'b0; slope_r = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2", gates(), 4'b1001);

    // R3: all off at first edge, then remaining gap
    phase = "R3";
    pair_req = 1'b1;
    @(negedge clk);
    chk("R3", gates(), 0);
    gap_len(n);
    chk("R3", n, MIN_CYC - 1);
    chk("R2", gates(), 4'b0110);

    // R4: early slope end does not shorten the gap
    phase = "R4";
    repeat (3) @(negedge clk);
    pair_req = 1'b0; slope_r = 1'b1;
    fork
      gap_len(n);
      begin repeat (5) @(negedge clk); slope_r = 1'b0; end
    join
    chk("R4", n, MIN_CYC);
    chk("R2", gates(), 4'b1001);

    // R5: leaving A watches left; right flag held longer is ignored
    phase = "R5";
    repeat (3) @(negedge clk);
    pair_req = 1'b1; slope_l = 1'b1; slope_r = 1'b1;
    fork
      gap_len(n);
      begin repeat (MIN_CYC + 50) @(negedge clk); slope_l = 1'b0; end
      begin repeat (MIN_CYC + 150) @(negedge clk); slope_r = 1'b0; end
    join
    chk("R5", n, MIN_CYC + 50);

    // R6: slope never ends
    phase = "R6";
    pair_req = 1'b0; slope_r = 1'b1;
    gap_len(n);
    chk("R6", n, MAX_CYC);
    chk("R6", gates(), 4'b1001);
    slope_r = 1'b0;

    // R7: reversal mid-gap
    phase = "R7";
    repeat (3) @(negedge clk);
    pair_req = 1'b1;
    fork
      gap_len(n);
      begin repeat (10) @(negedge clk); pair_req = 1'b0; end
    join
    chk("R7", n, MIN_CYC);
    chk("R7", gates(), 4'b0110);
    gap_len(n);
    chk("R7", n, MIN_CYC);
    chk("R7", gates(), 4'b1001);

    // R9: lockout on the left high side
    phase = "R9";
    hs_lock_l = 1'b1; hs_lock_r = 1'b1;
    @(negedge clk);
    chk("R9", gates(), 4'b0001);
    hs_lock_l = 1'b0;
    @(negedge clk);
    chk("R9", gates(), 4'b1001);
    hs_lock_r = 1'b0;

    // R8: disable during a gap, slopes high across release
    phase = "R8";
    pair_req = 1'b1;
    repeat (20) @(negedge clk);
    bridge_off = 1'b1; slope_l = 1'b1; slope_r = 1'b1;
    @(negedge clk);
    chk("R8", gates(), 0);
    repeat (5) @(negedge clk);
    chk("R8", gates(), 0);
    bridge_off = 1'b0;
    gap_len(n);
    chk("R8", n, MIN_CYC);
    chk("R8", gates(), 4'b0110);
    // R8: disable while a pair conducts
    bridge_off = 1'b1;
    @(negedge clk);
    chk("R8", gates(), 0);
    bridge_off = 1'b0;
    gap_len(n);
    chk("R8", n, MIN_CYC);
    chk("R8", gates(), 4'b0110);
    slope_l = 1'b0; slope_r = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule